// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Receiver

This block turns one asynchronous serial input line into received words. An external baud generator supplies a strobe at sixteen times the bit rate. The block synchronises the line, looks for a falling edge and confirms it at the middle of the start bit. It then samples each following bit at its centre and checks the stop bit. A 3-bit format selector picks one of five frame layouts: eight data bits, seven data bits plus parity, eight data bits plus parity, nine data bits, or eight data bits plus a wake-up bit. A control bit picks odd or even parity.

Each finished character is packed into a 10-bit word that carries its own parity and framing error flags. The word is pushed into a 16-entry queue, or into a single holding slot when queueing is switched off. A consumer drains words through a valid/ready pop port. The block also reports the state of the queue, the error flags of the word at the head, a sticky overrun indication and an inactivity timeout. The timeout is measured in whole character times.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset, pop_valid, st_full, st_half, st_perr, st_ferr, st_ovr and st_tmo are all 0.
- R2: With mode 3'b001, each word carries the eight received data bits, LSB first on the line, in bits [7:0], and bit 8 is 0. The unused encodings 3'b000, 3'b010 and 3'b110 behave the same way.
- R3: With mode 3'b011, seven data bits and then one parity bit are received. Bits [7:0] of the word hold those eight line bits in order, so bit 7 is the received parity bit. Bit 8 is 1 when the parity is wrong: the count of ones over the eight bits must be odd when odd_par=1 and even when odd_par=0.
- R4: With mode 3'b111, eight data bits and one parity bit are received. Bits [7:0] hold the data, and bit 8 is 1 when the parity over the nine bits is wrong, with the same odd/even rule as R3.
- R5: With mode 3'b100 (nine data bits) or mode 3'b101 (eight data bits plus a wake-up bit), bits [8:0] hold the nine received bits, and no parity check is made.
- R6: Bit 9 of a word is 1 when the line is low at the centre of the stop bit. st_ferr is 1 while the head word has bit 9 set, and st_perr is 1 while the head word has a parity error.
- R7: A start bit is accepted only if the line is still low eight oversample ticks after the falling edge, so a shorter low pulse produces no word. While rx_en is 0, no new frame is started.
- R8: With fifo_en=1, up to 16 words are held and popped in arrival order. st_full is 1 while at least one word is held, and st_half is 1 while at least 8 are held.
- R9: With fifo_en=0, only one word is held. A character that completes while that word is still unread is discarded.
- R10: A character that completes while no space is left is discarded and sets st_ovr. st_ovr stays 1 until a clr_err pulse clears it.
- R11: With tmo_chars=N (N>0), st_tmo rises once the queue has been non-empty with no new character for N character times (N x 160 ticks). It falls when the queue empties or a new character completes. N=0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Allows new frames to start |
| mode | input | 3 | Frame format selector |
| odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single slot |
| tmo_chars | input | 8 | Timeout length in character times, 0 = off |
| clr_err | input | 1 | Clears the sticky overrun flag |
| pop_ready | input | 1 | Consumer accepts the head word |
| pop_valid | output | 1 | A word is available |
| pop_data | output | 10 | Head word: framing flag, parity flag or ninth bit, data |
| st_full | output | 1 | At least one word is held |
| st_half | output | 1 | At least half the queue is occupied |
| st_perr | output | 1 | Head word has a parity error |
| st_ferr | output | 1 | Head word has a framing error |
| st_ovr | output | 1 | Sticky overrun |
| st_tmo | output | 1 | Inactivity timeout |

## Verification
A slip in the bit-phase counter or the bit index makes the word read back at the pop port shifted or truncated. It also corrupts the parity flag of that word, so the fault is visible on the first character popped after the frame. A wrong queue pointer or level shows up as words out of order, st_half toggling at the wrong count, or a drop and st_ovr one character early or late. A fault in the timeout counter shows as st_tmo rising far from N x 160 ticks after the last character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR       = 16;
    localparam int CHAR_BITS = 10;

    localparam logic [2:0] MODE_D8  = 3'b001;
    localparam logic [2:0] MODE_D7P = 3'b011;
    localparam logic [2:0] MODE_D8P = 3'b111;
    localparam logic [2:0] MODE_D9  = 3'b100;
    localparam logic [2:0] MODE_D8W = 3'b101;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       perr;
        logic [8:0] bits;
    } rx_word_t;

    // number of bits that follow the start bit
    function automatic logic [3:0] frame_bits(input logic [2:0] m);
        case (m)
            MODE_D8P, MODE_D9, MODE_D8W: frame_bits = 4'd9;
            default:                     frame_bits = 4'd8;
        endcase
    endfunction

    function automatic rx_word_t pack_word(input logic [2:0] m, input logic odd,
                                           input logic [8:0] sh, input logic stop_bit);
        rx_word_t w;
        w.ferr = ~stop_bit;
        w.perr = 1'b0;
        w.bits = {1'b0, sh[7:0]};
        case (m)
            MODE_D7P: begin
                w.perr    = (^sh[7:0]) != odd;
                w.bits[8] = w.perr;
            end
            MODE_D8P: begin
                w.perr    = (^sh[8:0]) != odd;
                w.bits[8] = w.perr;
            end
            MODE_D9, MODE_D8W: w.bits = sh;
            default: ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = OSR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [2:0] mode,
    input  logic       odd_par,
    output logic       char_vld,
    output rx_word_t   char_word
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] PH_MID = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] PH_END = CW'(OVERSAMPLE - 1);

    rx_state_e     state;
    logic [CW-1:0] ph;
    logic [3:0]    idx;
    logic [8:0]    sh;
    logic [2:0]    mode_q;
    logic          odd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            ph        <= '0;
            idx       <= '0;
            sh        <= '0;
            mode_q    <= '0;
            odd_q     <= 1'b0;
            char_vld  <= 1'b0;
            char_word <= '0;
        end else begin
            char_vld <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (rx_en && !rxd) begin
                            state  <= RX_START;
                            ph     <= '0;
                            mode_q <= mode;
                            odd_q  <= odd_par;
                        end
                    end
                    RX_START: begin
                        if (ph == PH_MID) begin
                            ph    <= '0;
                            idx   <= '0;
                            sh    <= '0;
                            state <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (ph == PH_END) begin
                            ph      <= '0;
                            sh[idx] <= rxd;
                            idx     <= idx + 1'b1;
                            if (idx == frame_bits(mode_q) - 4'd1)
                                state <= RX_STOP;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    default: begin
                        if (ph == PH_END) begin
                            ph        <= '0;
                            state     <= RX_IDLE;
                            char_vld  <= 1'b1;
                            char_word <= pack_word(mode_q, odd_q, sh, rxd);
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          push,
    input  rx_word_t      push_word,
    input  logic          pop,
    output rx_word_t      head,
    output logic [LW-1:0] lvl,
    output logic          drop
);
    rx_word_t          mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [LW-1:0]     cap;
    logic              accept, do_pop;

    assign cap    = fifo_en ? LW'(DEPTH) : LW'(1);
    assign accept = push && (lvl < cap);
    assign drop   = push && !accept;
    assign do_pop = pop && (lvl != '0);
    assign head   = mem[rptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            lvl  <= '0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (do_pop) rptr <= rptr + 1'b1;
            case ({accept, do_pop})
                2'b10:   lvl <= lvl + 1'b1;
                2'b01:   lvl <= lvl - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
    parameter int OVERSAMPLE = 16,
    parameter int CHAR_BITS  = 10,
    localparam int CHAR_TICKS = OVERSAMPLE * CHAR_BITS,
    localparam int TW = $clog2(CHAR_TICKS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  logic [7:0] limit,
    output logic       flag
);
    localparam logic [TW-1:0] T_LAST = TW'(CHAR_TICKS - 1);

    logic [TW-1:0] tcnt;
    logic [7:0]    ccnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tcnt <= '0;
            ccnt <= '0;
            flag <= 1'b0;
        end else if (tick && !flag && limit != 8'd0) begin
            if (tcnt == T_LAST) begin
                tcnt <= '0;
                ccnt <= ccnt + 1'b1;
                if (ccnt + 8'd1 == limit) flag <= 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [2:0] mode,
    input  logic       odd_par,
    input  logic       fifo_en,
    input  logic [7:0] tmo_chars,
    input  logic       clr_err,
    input  logic       pop_ready,
    output logic       pop_valid,
    output logic [9:0] pop_data,
    output logic       st_full,
    output logic       st_half,
    output logic       st_perr,
    output logic       st_ferr,
    output logic       st_ovr,
    output logic       st_tmo
);
    logic [1:0]    rxd_sync;
    logic          char_vld;
    rx_word_t      char_word;
    rx_word_t      head;
    logic [LW-1:0] lvl;
    logic          drop;
    logic          pop_fire;
    logic          tmo_restart;

    always_ff @(posedge clk) begin
        if (rst) rxd_sync <= 2'b11;
        else     rxd_sync <= {rxd_sync[0], rxd};
    end

    rx_deframer #(.OVERSAMPLE(OSR)) u_deframer (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd_sync[1]), .rx_en(rx_en),
        .mode(mode), .odd_par(odd_par), .char_vld(char_vld), .char_word(char_word)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .push(char_vld), .push_word(char_word),
        .pop(pop_fire), .head(head), .lvl(lvl), .drop(drop)
    );

    assign pop_valid   = (lvl != '0);
    assign pop_fire    = pop_valid && pop_ready;
    assign tmo_restart = char_vld || !pop_valid || (lvl == LW'(1) && pop_fire);

    rx_timeout #(.OVERSAMPLE(OSR), .CHAR_BITS(CHAR_BITS)) u_timeout (
        .clk(clk), .rst(rst), .tick(tick), .restart(tmo_restart),
        .limit(tmo_chars), .flag(st_tmo)
    );

    always_ff @(posedge clk) begin
        if (rst)          st_ovr <= 1'b0;
        else if (drop)    st_ovr <= 1'b1;
        else if (clr_err) st_ovr <= 1'b0;
    end

    assign pop_data = {head.ferr, head.bits};
    assign st_full  = pop_valid;
    assign st_half  = (lvl >= LW'(DEPTH / 2));
    assign st_perr  = pop_valid && head.perr;
    assign st_ferr  = pop_valid && head.ferr;
endmodule

// File: rtl/uart_rx_engine_chk.sv
module uart_rx_engine_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic [9:0]    pop_data,
    input logic          st_ovr,
    input logic          st_tmo,
    input logic          clr_err,
    input logic [LW-1:0] lvl,
    input logic          drop
);
    // R8: queue level never exceeds its depth
    a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
        lvl <= LW'(DEPTH));

    // R8: an unaccepted head word stays in place
    a_r8_head_hold: assert property (@(posedge clk) disable iff (rst)
        pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));

    // R10: overrun stays set until cleared
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        st_ovr && !clr_err |=> st_ovr);

    // R10: clear strobe without a new drop removes overrun
    a_r10_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        clr_err && !drop |=> !st_ovr);

    // R11: timeout only while words are held
    a_r11_tmo_needs_data: assert property (@(posedge clk) disable iff (rst)
        st_tmo |-> pop_valid);
endmodule

bind uart_rx_engine uart_rx_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .st_ovr(st_ovr), .st_tmo(st_tmo), .clr_err(clr_err),
    .lvl(lvl), .drop(drop)
);

// File: tb/uart_rx_engine_test.sv
module uart_rx_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [2:0] mode = 3'b001;
    logic       odd_par = 1'b0;
    logic       fifo_en = 1'b1;
    logic [7:0] tmo_chars = 8'd0;
    logic       clr_err = 1'b0;
    logic       pop_ready = 1'b0;
    logic       pop_valid;
    logic [9:0] pop_data;
    logic       st_full, st_half, st_perr, st_ferr, st_ovr, st_tmo;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_rx_engine uut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en), .mode(mode),
        .odd_par(odd_par), .fifo_en(fifo_en), .tmo_chars(tmo_chars), .clr_err(clr_err),
        .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
        .st_full(st_full), .st_half(st_half), .st_perr(st_perr), .st_ferr(st_ferr),
        .st_ovr(st_ovr), .st_tmo(st_tmo)
    );

    task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int nbits(input logic [2:0] m);
        return (m == 3'b111 || m == 3'b100 || m == 3'b101) ? 9 : 8;
    endfunction

    function automatic bit has_par(input logic [2:0] m);
        return (m == 3'b011 || m == 3'b111);
    endfunction

    // line bits after the start bit for a given payload
    function automatic logic [8:0] line_bits(input logic [2:0] m, input logic odd,
                                             input logic [8:0] d, input bit bad);
        logic p;
        case (m)
            3'b011: begin p = (^d[6:0]) ^ odd ^ bad; return {1'b0, p, d[6:0]}; end
            3'b111: begin p = (^d[7:0]) ^ odd ^ bad; return {p, d[7:0]}; end
            3'b100, 3'b101: return d;
            default: return {1'b0, d[7:0]};
        endcase
    endfunction

    function automatic logic [9:0] expect_word(input logic [2:0] m, input logic [8:0] lb,
                                               input bit bad, input bit stop_ok);
        if (has_par(m))                  return {~stop_ok, bad, lb[7:0]};
        if (m == 3'b100 || m == 3'b101)  return {~stop_ok, lb};
        return {~stop_ok, 1'b0, lb[7:0]};
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] lb, input int n, input bit stop_ok);
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(lb[i]);
        drive_bit(stop_ok);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic pop_one(output logic [9:0] w);
        w = pop_data;
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic clear_ovr;
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    // send one character, then check and pop it
    task automatic frame_check(input string req, input logic [2:0] m, input logic odd,
                               input logic [8:0] d, input bit bad, input bit stop_ok);
        logic [8:0] lb;
        logic [9:0] w;
        bit eff_bad;
        eff_bad = bad && has_par(m);
        mode = m;
        odd_par = odd;
        lb = line_bits(m, odd, d, eff_bad);
        send(lb, nbits(m), stop_ok);
        check(req, {9'd0, pop_valid}, 10'd1);
        check(req, {8'd0, st_perr, st_ferr}, {8'd0, eff_bad, ~stop_ok});
        pop_one(w);
        check(req, w, expect_word(m, lb, eff_bad, stop_ok));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] w;
        logic [8:0] data_q [16];
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", {3'd0, pop_valid, st_full, st_half, st_perr, st_ferr, st_ovr, st_tmo}, 10'd0);

        // R2 plain 8-bit and unused encodings
        frame_check("R2", 3'b001, 1'b0, 9'h0A5, 0, 1);
        frame_check("R2", 3'b000, 1'b1, 9'h13C, 0, 1);
        frame_check("R2", 3'b110, 1'b0, 9'h081, 0, 1);

        // R3 seven bits plus parity, both senses, good and bad
        frame_check("R3", 3'b011, 1'b1, 9'h05A, 0, 1);
        frame_check("R3", 3'b011, 1'b1, 9'h05A, 1, 1);
        frame_check("R3", 3'b011, 1'b0, 9'h07F, 1, 1);

        // R4 eight bits plus parity
        frame_check("R4", 3'b111, 1'b0, 9'h0C3, 0, 1);
        frame_check("R4", 3'b111, 1'b0, 9'h0C3, 1, 1);
        frame_check("R4", 3'b111, 1'b1, 9'h0FE, 0, 1);

        // R5 nine bits and wake-up bit
        frame_check("R5", 3'b100, 1'b0, 9'h1A5, 0, 1);
        frame_check("R5", 3'b101, 1'b1, 9'h0FF, 0, 1);

        // R6 framing error
        frame_check("R6", 3'b001, 1'b0, 9'h055, 0, 0);
        frame_check("R6", 3'b111, 1'b1, 9'h0AA, 1, 0);

        // R7 short glitch gives no word
        mode = 3'b001;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R7 glitch", {9'd0, pop_valid}, 10'd0);
        // R7 receiver disabled gives no word
        rx_en = 1'b0;
        send(9'h033, 8, 1);
        check("R7 disabled", {9'd0, pop_valid}, 10'd0);
        rx_en = 1'b1;

        // R8 ordering and half flag, R10 overrun on 17th
        mode = 3'b100;
        for (int i = 0; i < 17; i++) begin
            logic [8:0] d;
            d = 9'($urandom);
            if (i < 16) data_q[i] = d;
            send(d, 9, 1);
            if (i == 6)  check("R8 half below", {9'd0, st_half}, 10'd0);
            if (i == 7)  check("R8 half at 8", {9'd0, st_half}, 10'd1);
            if (i == 15) check("R10 no ovr at 16", {9'd0, st_ovr}, 10'd0);
        end
        check("R10 ovr set", {9'd0, st_ovr}, 10'd1);
        check("R8 full", {9'd0, st_full}, 10'd1);
        for (int i = 0; i < 16; i++) begin
            pop_one(w);
            check("R8 order", w, {1'b0, data_q[i]});
        end
        check("R8 drained", {8'd0, pop_valid, st_full}, 10'd0);
        check("R10 ovr sticky", {9'd0, st_ovr}, 10'd1);
        clear_ovr();
        check("R10 ovr cleared", {9'd0, st_ovr}, 10'd0);

        // R9 single slot
        fifo_en = 1'b0;
        mode = 3'b001;
        send(9'h011, 8, 1);
        send(9'h022, 8, 1);
        check("R9 ovr", {9'd0, st_ovr}, 10'd1);
        pop_one(w);
        check("R9 first kept", w, 10'h011);
        check("R9 second dropped", {9'd0, pop_valid}, 10'd0);
        clear_ovr();
        fifo_en = 1'b1;

        // R11 timeout after two character times
        tmo_chars = 8'd2;
        send(9'h044, 8, 1);
        repeat (250) @(negedge clk);
        check("R11 early", {9'd0, st_tmo}, 10'd0);
        repeat (80) @(negedge clk);
        check("R11 raised", {9'd0, st_tmo}, 10'd1);
        pop_one(w);
        check("R11 cleared", {9'd0, st_tmo}, 10'd0);
        tmo_chars = 8'd0;

        // random frames across all modes (R2 R3 R4 R5 R6)
        for (int i = 0; i < 30; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            frame_check("R2-R6 random", m, 1'($urandom), 9'($urandom),
                        ($urandom % 4) == 0, ($urandom % 8) != 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule